// File: doc/BRIEF.md
# Multicast Cell Write Controller

This block controls the write side of a cell buffer that has one input and four output queues. Before a cell is sent, an upstream switch places a destination mask on the data bus. The mask can select any set of the four queues. The controller registers the mask and then reports whether every selected queue has room for a complete cell. When the upstream starts the cell, each word of the cell is pushed into all selected queues in the same cycle. A single cell can therefore be stored several times.

The queues belong to the surrounding logic. They present their occupancy counts to the controller and take the push strobes and the shared write word from it. A separate poll strobe lets the upstream load the destination mask for the next cell while the current cell is still arriving. The cell in flight keeps its original destinations. When the stored mask is all zero, the controller stops driving the availability line. When the upstream starts a cell without room, the controller discards the whole cell and raises an error flag.

Top module: `mcast_cell_wr`

## Requirements
- R1: A word is an address word in two cases: `in_en` high with `in_soc` low while no cell is open, or `in_poll` high in any state. In an address word, bits [NUM_Q-1:0] of `in_data` become the destination mask, and bit i selects queue i. An address word is never pushed to any queue.
- R2: `cav` is registered. One cycle after each edge it shows whether the mask is non-zero and every selected queue satisfies Q_DEPTH − level − pending ≥ CELL_LEN. Pending counts pushes not yet reflected in the level plus the unwritten words of the open cell. The value is recomputed every cycle, so it rises when a full queue drains, even with no new address word.
- R3: `cav_oe` is high exactly when the stored mask is non-zero. When `cav_oe` is low, `cav` is low.
- R4: A cell starts with `in_en` and `in_soc` both high while idle and `cav` high. That word and the next CELL_LEN−1 data words are each pushed on `q_push` one cycle after they are taken, to exactly the selected queues, with the word unchanged on `q_wdata`. A data word is `in_en` high with `in_poll` low.
- R5: Consecutive cells to the same mask stream with no idle cycle between the last word of one cell and the start word of the next.
- R6: A new mask costs exactly one cycle. An address word directly after the last data word, followed at once by a start word, delivers the next cell to the new mask.
- R7: A mask polled while a cell is open does not change the queues that receive that cell. The new mask applies from the next start word.
- R8: A start word taken while `cav` is low discards the whole cell (CELL_LEN words) and pushes nothing. `ovf_err` is high for exactly the one cycle after that start word.
- R9: With an all-zero mask, no data word reaches any queue.
- R10: While `rst` is high, `cav`, `cav_oe`, `q_push` and `ovf_err` are all low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_data | input | DATA_W | Input word: destination mask or cell data |
| in_en | input | 1 | Word valid |
| in_soc | input | 1 | Marks the first word of a cell |
| in_poll | input | 1 | Loads a destination mask in any state |
| cav | output | 1 | Every selected queue has room for a whole cell |
| cav_oe | output | 1 | Drive enable for `cav` |
| q_level | input | NUM_Q*LVL_W | Occupancy of each queue, queue i in slice i |
| q_push | output | NUM_Q | Push strobe for each queue |
| q_wdata | output | DATA_W | Word written to the pushed queues |
| ovf_err | output | 1 | One-cycle pulse when a cell is discarded |

## Verification
The bench builds the controller with Q_DEPTH = 16 and CELL_LEN = 5. Queue levels can then be preset to the exact-fit point (11), to one entry short of it (12) and to full (16), and each cell takes only a few cycles. With these short cells the bench can check the last-word/start-word boundary, polling in the middle of a cell, and the full swallowing of a discarded cell in tight directed sequences. The sequences run after the table of mask and level patterns.

// File: rtl/mcast_cell_pkg.sv
package mcast_cell_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PASS = 2'd1,
    ST_DROP = 2'd2
  } seq_state_t;
endpackage

// File: rtl/mcast_cell_seq.sv
module mcast_cell_seq
  import mcast_cell_pkg::*;
#(
  parameter int NUM_Q    = 4,
  parameter int CELL_LEN = 27,
  parameter int CNT_W    = $clog2(CELL_LEN + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_en,
  input  logic             in_soc,
  input  logic             in_poll,
  input  logic [NUM_Q-1:0] in_mask,
  input  logic             cav_i,
  output logic [NUM_Q-1:0] mask_nx_o,
  output logic [NUM_Q-1:0] cur_mask_o,
  output logic [NUM_Q-1:0] wr_mask_o,
  output logic [NUM_Q-1:0] res_mask_o,
  output logic [CNT_W-1:0] res_cnt_o,
  output logic             acc_o,
  output logic             drop_o
);
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(CELL_LEN - 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(CELL_LEN);

  seq_state_t       state;
  logic [CNT_W-1:0] wcnt;
  logic [NUM_Q-1:0] pend_mask;
  logic [NUM_Q-1:0] cur_mask;

  logic idle, addr_w, soc_w, mid_w, start;

  assign idle   = (state == ST_IDLE);
  assign addr_w = in_poll | (in_en & ~in_soc & idle);
  assign soc_w  = in_en & in_soc & ~in_poll & idle;
  assign mid_w  = in_en & ~in_poll & ~idle;
  assign start  = soc_w & cav_i;

  assign drop_o     = soc_w & ~cav_i;
  assign acc_o      = start | (mid_w & (state == ST_PASS));
  assign wr_mask_o  = start ? pend_mask : cur_mask;
  assign mask_nx_o  = addr_w ? in_mask : pend_mask;
  assign cur_mask_o = cur_mask;

  // Reservation for the cell that is still to be written (edge inclusive)
  always_comb begin
    res_mask_o = '0;
    res_cnt_o  = '0;
    if (start) begin
      res_mask_o = pend_mask;
      res_cnt_o  = FULL_CNT;
    end else if (state == ST_PASS) begin
      res_mask_o = cur_mask;
      res_cnt_o  = FULL_CNT - wcnt;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      wcnt      <= '0;
      pend_mask <= '0;
      cur_mask  <= '0;
    end else begin
      if (addr_w) pend_mask <= in_mask;
      unique case (state)
        ST_IDLE: begin
          if (start) begin
            cur_mask <= pend_mask;
            if (CELL_LEN > 1) begin
              state <= ST_PASS;
              wcnt  <= CNT_W'(1);
            end
          end else if (soc_w && CELL_LEN > 1) begin
            state <= ST_DROP;
            wcnt  <= CNT_W'(1);
          end
        end
        ST_PASS, ST_DROP: begin
          if (mid_w) begin
            if (wcnt == LAST_IDX) begin
              state <= ST_IDLE;
              wcnt  <= '0;
            end else begin
              wcnt <= wcnt + CNT_W'(1);
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_DROP_SILENT: assert property (@(posedge clk) disable iff (rst)
    (state == ST_DROP) |-> !acc_o); // R8
  AST_OPEN_CELL_HAS_DEST: assert property (@(posedge clk) disable iff (rst)
    (state == ST_PASS) |-> (cur_mask != '0)); // R9
  AST_DEST_STABLE_IN_CELL: assert property (@(posedge clk) disable iff (rst)
    (state == ST_PASS && $past(state) == ST_PASS) |-> $stable(cur_mask)); // R7
  AST_WCNT_RANGE: assert property (@(posedge clk) disable iff (rst)
    wcnt < FULL_CNT); // R4
endmodule

// File: rtl/mcast_cell_room.sv
module mcast_cell_room #(
  parameter int NUM_Q    = 4,
  parameter int Q_DEPTH  = 128,
  parameter int CELL_LEN = 27,
  parameter int LVL_W    = $clog2(Q_DEPTH + 1),
  parameter int CNT_W    = $clog2(CELL_LEN + 1)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [NUM_Q*LVL_W-1:0] lvl_i,
  input  logic [NUM_Q-1:0]       push_i,
  input  logic [NUM_Q-1:0]       mask_i,
  input  logic [NUM_Q-1:0]       res_mask_i,
  input  logic [CNT_W-1:0]       res_cnt_i,
  output logic                   cav_o,
  output logic                   oe_o
);
  localparam int SUM_W = $clog2(Q_DEPTH + 2 * CELL_LEN + 2) + 1;

  logic [NUM_Q-1:0] ok;

  for (genvar q = 0; q < NUM_Q; q++) begin : g_queue
    logic [SUM_W-1:0] used;
    logic             fit;
    assign used = SUM_W'(lvl_i[q*LVL_W +: LVL_W]) + SUM_W'(push_i[q])
                + (res_mask_i[q] ? SUM_W'(res_cnt_i) : '0);
    assign fit  = (used + SUM_W'(CELL_LEN)) <= SUM_W'(Q_DEPTH);
    assign ok[q] = ~mask_i[q] | fit;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cav_o <= 1'b0;
      oe_o  <= 1'b0;
    end else begin
      cav_o <= (|mask_i) & (&ok);
      oe_o  <= |mask_i;
    end
  end

  AST_OE_GATES_CAV: assert property (@(posedge clk) disable iff (rst)
    cav_o |-> oe_o); // R3
endmodule

// File: rtl/mcast_cell_wr.sv
module mcast_cell_wr #(
  parameter int DATA_W   = 18,
  parameter int NUM_Q    = 4,
  parameter int Q_DEPTH  = 128,
  parameter int CELL_LEN = 27,
  parameter int LVL_W    = $clog2(Q_DEPTH + 1)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [DATA_W-1:0]      in_data,
  input  logic                   in_en,
  input  logic                   in_soc,
  input  logic                   in_poll,
  output logic                   cav,
  output logic                   cav_oe,
  input  logic [NUM_Q*LVL_W-1:0] q_level,
  output logic [NUM_Q-1:0]       q_push,
  output logic [DATA_W-1:0]      q_wdata,
  output logic                   ovf_err
);
  localparam int CNT_W = $clog2(CELL_LEN + 1);

  logic [NUM_Q-1:0] mask_nx, cur_mask, wr_mask, res_mask;
  logic [CNT_W-1:0] res_cnt;
  logic             acc, drop, cav_r;

  mcast_cell_seq #(
    .NUM_Q(NUM_Q), .CELL_LEN(CELL_LEN), .CNT_W(CNT_W)
  ) i_seq (
    .clk(clk), .rst(rst),
    .in_en(in_en), .in_soc(in_soc), .in_poll(in_poll),
    .in_mask(in_data[NUM_Q-1:0]), .cav_i(cav_r),
    .mask_nx_o(mask_nx), .cur_mask_o(cur_mask), .wr_mask_o(wr_mask),
    .res_mask_o(res_mask), .res_cnt_o(res_cnt),
    .acc_o(acc), .drop_o(drop)
  );

  mcast_cell_room #(
    .NUM_Q(NUM_Q), .Q_DEPTH(Q_DEPTH), .CELL_LEN(CELL_LEN),
    .LVL_W(LVL_W), .CNT_W(CNT_W)
  ) i_room (
    .clk(clk), .rst(rst),
    .lvl_i(q_level), .push_i(q_push), .mask_i(mask_nx),
    .res_mask_i(res_mask), .res_cnt_i(res_cnt),
    .cav_o(cav_r), .oe_o(cav_oe)
  );

  assign cav = cav_r;

  always_ff @(posedge clk) begin
    if (rst) begin
      q_push  <= '0;
      q_wdata <= '0;
      ovf_err <= 1'b0;
    end else begin
      q_push  <= acc ? wr_mask : '0;
      ovf_err <= drop;
      if (acc) q_wdata <= in_data;
    end
  end

  AST_PUSH_IN_MASK: assert property (@(posedge clk) disable iff (rst)
    (|q_push) |-> ((q_push & ~cur_mask) == '0)); // R4
  AST_DISCARD_NO_PUSH: assert property (@(posedge clk) disable iff (rst)
    ovf_err |-> (q_push == '0)); // R8

  for (genvar g = 0; g < NUM_Q; g++) begin : g_chk
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
      q_push[g] |-> (q_level[g*LVL_W +: LVL_W] < LVL_W'(Q_DEPTH))); // R2
  end
endmodule

// File: tb/test_mcast_cell_wr.sv
`timescale 1ns/1ps
module test_mcast_cell_wr;
  localparam int DATA_W = 18;
  localparam int NUM_Q = 4;
  localparam int Q_DEPTH = 16;
  localparam int CELL_LEN = 5;
  localparam int LVL_W = $clog2(Q_DEPTH + 1);
  localparam int NVEC = 8;
  // {mask[24:21], lvl0, lvl1, lvl2, lvl3 (5 bits each), expected cav[0]}
  localparam logic [24:0] VEC [NVEC] = '{
    {4'b0001, 5'd0,  5'd0,  5'd0,  5'd0,  1'b1},
    {4'b1111, 5'd11, 5'd11, 5'd11, 5'd11, 1'b1},
    {4'b1111, 5'd11, 5'd12, 5'd0,  5'd0,  1'b0},
    {4'b0101, 5'd0,  5'd16, 5'd0,  5'd16, 1'b1},
    {4'b1010, 5'd0,  5'd16, 5'd0,  5'd3,  1'b0},
    {4'b0000, 5'd0,  5'd0,  5'd0,  5'd0,  1'b0},
    {4'b0110, 5'd5,  5'd11, 5'd11, 5'd16, 1'b1},
    {4'b1000, 5'd0,  5'd0,  5'd0,  5'd12, 1'b0}
  };

  logic clk = 1'b0;
  logic rst;
  logic [DATA_W-1:0] in_data;
  logic in_en, in_soc, in_poll;
  logic cav, cav_oe, ovf_err;
  logic [NUM_Q*LVL_W-1:0] q_level;
  logic [NUM_Q-1:0] q_push;
  logic [DATA_W-1:0] q_wdata;

  logic [LVL_W-1:0] lvl_base [NUM_Q];
  logic [15:0] pcnt [NUM_Q];
  logic [31:0] qsum [NUM_Q];
  int snap_p [NUM_Q];
  int snap_s [NUM_Q];
  int nchk = 0;
  int nerr = 0;

  always #2.5 clk = ~clk;

  mcast_cell_wr #(
    .DATA_W(DATA_W), .NUM_Q(NUM_Q), .Q_DEPTH(Q_DEPTH), .CELL_LEN(CELL_LEN)
  ) i_mcast_cell_wr (
    .clk(clk), .rst(rst), .in_data(in_data), .in_en(in_en),
    .in_soc(in_soc), .in_poll(in_poll), .cav(cav), .cav_oe(cav_oe),
    .q_level(q_level), .q_push(q_push), .q_wdata(q_wdata), .ovf_err(ovf_err)
  );

  // Queue model: push count and data sum per queue
  always_ff @(posedge clk) begin
    for (int i = 0; i < NUM_Q; i++) begin
      if (rst) begin
        pcnt[i] <= '0;
        qsum[i] <= '0;
      end else if (q_push[i]) begin
        pcnt[i] <= pcnt[i] + 16'd1;
        qsum[i] <= qsum[i] + 32'(q_wdata);
      end
    end
  end

  always_comb begin
    for (int i = 0; i < NUM_Q; i++)
      q_level[i*LVL_W +: LVL_W] = lvl_base[i] + pcnt[i][LVL_W-1:0];
  end

  task automatic check(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc(input logic en, input logic soc, input logic poll, input int d);
    in_en = en; in_soc = soc; in_poll = poll; in_data = DATA_W'(d);
    @(negedge clk);
    in_en = 1'b0; in_soc = 1'b0; in_poll = 1'b0; in_data = '0;
  endtask

  task automatic setlvl(input int q, input int v);
    lvl_base[q] = LVL_W'(v) - pcnt[q][LVL_W-1:0];
  endtask

  task automatic snap();
    for (int i = 0; i < NUM_Q; i++) begin
      snap_p[i] = int'(pcnt[i]);
      snap_s[i] = int'(qsum[i]);
    end
  endtask

  task automatic send_cell(input int base);
    cyc(1, 1, 0, base);
    for (int k = 1; k < CELL_LEN; k++) cyc(1, 0, 0, base + k);
  endtask

  function automatic int cell_sum(input int base);
    return CELL_LEN * base + CELL_LEN * (CELL_LEN - 1) / 2;
  endfunction

  task automatic check_q(input string req, input int q, input int ncell, input int sum);
    check(req, int'(pcnt[q]) - snap_p[q], ncell * CELL_LEN);
    check(req, int'(qsum[q]) - snap_s[q], sum);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nchk++; nerr++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    rst = 1'b1;
    in_en = 1'b0; in_soc = 1'b0; in_poll = 1'b0; in_data = '0;
    for (int i = 0; i < NUM_Q; i++) lvl_base[i] = '0;
    repeat (3) @(negedge clk);
    check("R10 cav", int'(cav), 0);
    check("R10 cav_oe", int'(cav_oe), 0);
    check("R10 q_push", int'(q_push), 0);
    check("R10 ovf_err", int'(ovf_err), 0);
    rst = 1'b0;
    @(negedge clk);

    // Table of mask / level patterns
    for (int v = 0; v < NVEC; v++) begin
      logic [3:0] m;
      logic ec;
      int base;
      m = VEC[v][24:21];
      ec = VEC[v][0];
      base = 100 * (v + 1);
      for (int i = 0; i < NUM_Q; i++) setlvl(i, int'(VEC[v][20 - 5*i -: 5]));
      cyc(1, 0, 0, int'(m));
      check("R1 address word not pushed", int'(q_push), 0);
      check("R2 cav after address", int'(cav), int'(ec));
      check("R3 cav_oe follows mask", int'(cav_oe), int'(|m));
      snap();
      cyc(1, 1, 0, base);
      check("R8 ovf on start without room", int'(ovf_err), int'(!ec));
      for (int k = 1; k < CELL_LEN; k++) cyc(1, 0, 0, base + k);
      cyc(0, 0, 0, 0);
      for (int i = 0; i < NUM_Q; i++) begin
        if (m == 4'b0000)
          check_q("R9 zero mask writes nothing", i, 0, 0);
        else if (ec && m[i])
          check_q("R4 cell copied to selected queue", i, 1, cell_sum(base));
        else
          check_q("R4 R8 unselected or dropped queue untouched", i, 0, 0);
      end
    end

    // R5: back-to-back cells, same mask
    for (int i = 0; i < NUM_Q; i++) setlvl(i, 0);
    cyc(1, 0, 0, 4'b0011);
    snap();
    send_cell(1000);
    send_cell(2000);
    cyc(0, 0, 0, 0);
    cyc(0, 0, 0, 0);
    check_q("R5 back-to-back q0", 0, 2, cell_sum(1000) + cell_sum(2000));
    check_q("R5 back-to-back q1", 1, 2, cell_sum(1000) + cell_sum(2000));
    check_q("R5 back-to-back q2", 2, 0, 0);

    // R6: one address cycle between cells switches destination
    snap();
    send_cell(3000);
    cyc(1, 0, 0, 4'b1100);
    send_cell(4000);
    cyc(0, 0, 0, 0);
    cyc(0, 0, 0, 0);
    check_q("R6 old mask q0", 0, 1, cell_sum(3000));
    check_q("R6 new mask q2", 2, 1, cell_sum(4000));
    check_q("R6 new mask q3", 3, 1, cell_sum(4000));

    // R7: poll inside a cell keeps the cell's destination
    for (int i = 0; i < NUM_Q; i++) setlvl(i, 0);
    cyc(1, 0, 0, 4'b0001);
    snap();
    cyc(1, 1, 0, 5000);
    cyc(1, 0, 0, 5001);
    cyc(1, 0, 0, 5002);
    cyc(0, 0, 1, 4'b0010);
    cyc(1, 0, 0, 5003);
    cyc(1, 0, 0, 5004);
    send_cell(6000);
    cyc(0, 0, 0, 0);
    cyc(0, 0, 0, 0);
    check_q("R7 cell in flight stays on q0", 0, 1, cell_sum(5000));
    check_q("R7 polled mask used for next cell", 1, 1, cell_sum(6000));
    check_q("R7 q2 untouched", 2, 0, 0);

    // R2: refresh while idle when a queue drains
    setlvl(3, 12);
    cyc(1, 0, 0, 4'b1000);
    check("R2 no room at level 12", int'(cav), 0);
    setlvl(3, 11);
    cyc(0, 0, 0, 0);
    check("R2 refreshed after drain", int'(cav), 1);

    // R8: discarded cell swallows all words, pulse lasts one cycle
    setlvl(3, 12);
    cyc(0, 0, 0, 0);
    snap();
    cyc(1, 1, 0, 7000);
    check("R8 ovf pulse", int'(ovf_err), 1);
    cyc(1, 0, 0, 7001);
    check("R8 ovf one cycle only", int'(ovf_err), 0);
    for (int k = 2; k < CELL_LEN; k++) cyc(1, 0, 0, 7000 + k);
    setlvl(3, 0);
    cyc(0, 0, 0, 0);
    check_q("R8 discarded cell not written", 3, 0, 0);
    snap();
    send_cell(8000);
    cyc(0, 0, 0, 0);
    cyc(0, 0, 0, 0);
    check_q("R8 next cell accepted after discard", 3, 1, cell_sum(8000));

    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule